// File: doc/BRIEF.md
# Per-Field Alarm Match Unit

This block watches a calendar clock held in BCD and raises an alarm when the time reaches a programmed moment. Six alarm registers hold the target for seconds, minutes, hours, day of month, month and weekday. Each register has its own enable bit in bit 7, and only the enabled fields take part in the comparison. Enabling only the seconds field, for example, gives an alarm once a minute. Enabling seconds and minutes gives one once an hour.

The live time is compared once for each one-second strobe. A strobe that finds every enabled field equal produces a single-cycle event. The event also sets a sticky status flag, which stays set until a clear strobe removes it. The interrupt request is that flag gated by an alarm interrupt enable bit. When no field is enabled, the alarm never fires. After reset every alarm register is 00h, so the alarm starts disabled. Software loads the registers through a simple write port and reads them back through a combinational read port.

Top module: `alarm_field_matcher`

## Requirements
- R1: After reset, every alarm register reads 00h, and alarm_event, alarm_flag and alarm_irq are 0.
- R2: A write with wr_en stores into register wr_sel. The indices are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 weekday. Bit 7 is the field enable. The value widths are 7, 7, 6, 6, 5 and 3 bits in that index order. Value bits above the width read back as 0. rd_data shows register rd_sel in the same cycle. Writes to indices 6 and 7 have no effect, and reading those indices returns 00h.
- R3: When sec_tick is high at a clock edge and at least one field is enabled, and every enabled field equals the matching live time input, alarm_event is high for exactly the following cycle.
- R4: With no field enabled, alarm_event never rises, whatever the live time.
- R5: A disabled field takes no part in the match, so a mismatch in that field does not stop an event.
- R6: Without sec_tick, a matching time produces no event.
- R7: alarm_flag goes high in the same cycle as alarm_event and stays high until flag_clr is sampled high at a clock edge. If a new match and flag_clr fall on the same edge, the flag stays set.
- R8: alarm_irq equals alarm_flag AND alarm_ie, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Index of the register to write |
| wr_data | input | 8 | Write data: bit 7 is the enable, the low bits are the BCD value |
| rd_sel | input | 3 | Index of the register to read |
| rd_data | output | 8 | Contents of register rd_sel |
| cur_sec | input | 7 | Live seconds, BCD |
| cur_min | input | 7 | Live minutes, BCD |
| cur_hour | input | 6 | Live hours, BCD |
| cur_date | input | 6 | Live day of month, BCD |
| cur_month | input | 5 | Live month, BCD |
| cur_wday | input | 3 | Live weekday, 0 to 6 |
| sec_tick | input | 1 | One-second strobe, one cycle wide |
| alarm_ie | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clears the sticky flag |
| alarm_event | output | 1 | One-cycle alarm pulse |
| alarm_flag | output | 1 | Sticky alarm status |
| alarm_irq | output | 1 | Gated interrupt request |

## Verification
Each result has a fixed latency:
- A write appears on rd_data one cycle later.
- A reading through rd_sel is valid in the same cycle.
- alarm_event and alarm_flag change one cycle after the edge that samples sec_tick or flag_clr.
- alarm_irq follows alarm_flag and alarm_ie with no delay.

The bench drives inputs 1 ns after a rising edge and predicts the next state in its model from the inputs it has just applied. It then compares all outputs 1 ns after the following edge. Every result is therefore checked in exactly the cycle it is due.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int DATA_W     = 8;
  localparam int VAL_W      = DATA_W - 1;
  localparam int SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5
  } field_e;

  // number of meaningful BCD value bits per field
  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      5:       return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] value_mask(input int idx);
    logic [VAL_W-1:0] m;
    m = '0;
    for (int b = 0; b < VAL_W; b++) begin
      if (b < field_width(idx)) m[b] = 1'b1;
    end
    return m;
  endfunction

  // a disabled field always counts as a hit
  function automatic logic field_hit(input logic en,
                                     input logic [VAL_W-1:0] target,
                                     input logic [VAL_W-1:0] live,
                                     input logic [VAL_W-1:0] mask);
    return !en || ((target & mask) == (live & mask));
  endfunction
endpackage

// File: rtl/alm_field_reg.sv
module alm_field_reg
  import alm_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_o,
  output logic [VAL_W-1:0]  val_o
);
  localparam logic [VAL_W-1:0] MASK = value_mask(IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= 1'b0;
      val_o <= '0;
    end else if (wr_stb) begin
      en_o  <= wr_data[DATA_W-1];
      val_o <= wr_data[VAL_W-1:0] & MASK;
    end
  end
endmodule

// File: rtl/alm_match_cmp.sv
module alm_match_cmp
  import alm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0]            en_i,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0] target_i,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0] live_i,
  output logic [NUM_FIELDS-1:0]            hit_o,
  output logic                             all_hit_o,
  output logic                             any_en_o
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign hit_o[g] = field_hit(en_i[g], target_i[g], live_i[g], value_mask(g));
  end

  assign all_hit_o = &hit_o;
  assign any_en_o  = |en_i;
endmodule

// File: rtl/alm_event_gen.sv
module alm_event_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic all_hit_i,
  input  logic any_en_i,
  output logic fire_o,
  output logic event_o
);
  assign fire_o = tick_i && any_en_i && all_hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_o <= 1'b0;
    else        event_o <= fire_o;
  end

  AST_EVENT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(tick_i)); // R6
  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(any_en_i)); // R4
  AST_EVENT_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(all_hit_i)); // R5
endmodule

// File: rtl/alm_status_flag.sv
module alm_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & ie_i;

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !clr_i |=> flag_o); // R7
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_o); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R7
endmodule

// File: rtl/alarm_field_matcher.sv
module alarm_field_matcher
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_date,
  input  logic [4:0]        cur_month,
  input  logic [2:0]        cur_wday,
  input  logic              sec_tick,
  input  logic              alarm_ie,
  input  logic              flag_clr,
  output logic              alarm_event,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  logic [NUM_FIELDS-1:0]            wr_stb;
  logic [NUM_FIELDS-1:0]            fld_en;
  logic [NUM_FIELDS-1:0][VAL_W-1:0] fld_val;
  logic [NUM_FIELDS-1:0][VAL_W-1:0] live_val;
  logic [NUM_FIELDS-1:0]            fld_hit;
  logic                             all_hit;
  logic                             any_en;
  logic                             fire_now;

  assign live_val[FLD_SEC]   = VAL_W'(cur_sec);
  assign live_val[FLD_MIN]   = VAL_W'(cur_min);
  assign live_val[FLD_HOUR]  = VAL_W'(cur_hour);
  assign live_val[FLD_DATE]  = VAL_W'(cur_date);
  assign live_val[FLD_MONTH] = VAL_W'(cur_month);
  assign live_val[FLD_WDAY]  = VAL_W'(cur_wday);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_reg
    assign wr_stb[g] = wr_en && (wr_sel == SEL_W'(g));
    alm_field_reg #(.IDX(g)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb[g]),
      .wr_data(wr_data),
      .en_o   (fld_en[g]),
      .val_o  (fld_val[g])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rd_sel == SEL_W'(i)) rd_data = {fld_en[i], fld_val[i]};
    end
  end

  alm_match_cmp u_cmp (
    .en_i     (fld_en),
    .target_i (fld_val),
    .live_i   (live_val),
    .hit_o    (fld_hit),
    .all_hit_o(all_hit),
    .any_en_o (any_en)
  );

  alm_event_gen u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (sec_tick),
    .all_hit_i(all_hit),
    .any_en_i (any_en),
    .fire_o   (fire_now),
    .event_o  (alarm_event)
  );

  alm_status_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fire_now),
    .clr_i (flag_clr),
    .ie_i  (alarm_ie),
    .flag_o(alarm_flag),
    .irq_o (alarm_irq)
  );

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_event |-> alarm_flag); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_ie |-> !alarm_irq); // R8
  AST_UNUSED_SEL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel >= SEL_W'(NUM_FIELDS)) |-> (rd_data == '0)); // R2
endmodule

// File: tb/alarm_field_matcher_bench.sv
`timescale 1ns/1ps
module alarm_field_matcher_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_date = '0;
  logic [4:0] cur_month = '0;
  logic [2:0] cur_wday = '0;
  logic       sec_tick = 1'b0;
  logic       alarm_ie = 1'b0;
  logic       flag_clr = 1'b0;
  logic       alarm_event, alarm_flag, alarm_irq;

  always #2.5 clk = ~clk;

  alarm_field_matcher u_alarm_field_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_date(cur_date), .cur_month(cur_month),
    .cur_wday(cur_wday), .sec_tick(sec_tick), .alarm_ie(alarm_ie),
    .flag_clr(flag_clr), .alarm_event(alarm_event), .alarm_flag(alarm_flag),
    .alarm_irq(alarm_irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";
  int    events_seen = 0;

  // reference model state
  bit       m_en[6];
  int       m_val[6];
  bit       m_evt = 0;
  bit       m_flag = 0;

  function automatic int width_of(int i);
    int w[6] = '{7, 7, 6, 6, 5, 3};
    return w[i];
  endfunction

  function automatic int bcd(int n);
    return ((n / 10) * 16) + (n % 10);
  endfunction

  function automatic int live_of(int i);
    case (i)
      0: return int'(cur_sec);
      1: return int'(cur_min);
      2: return int'(cur_hour);
      3: return int'(cur_date);
      4: return int'(cur_month);
      default: return int'(cur_wday);
    endcase
  endfunction

  function automatic bit model_fire();
    bit any = 0;
    bit ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (m_en[i]) begin
        any = 1;
        if ((live_of(i) % (1 << width_of(i))) != m_val[i]) ok = 0;
      end
    end
    return any && ok;
  endfunction

  function automatic int model_read(int s);
    if (s > 5) return 0;
    return (m_en[s] ? 128 : 0) + m_val[s];
  endfunction

  task automatic check(string what, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    check("alarm_event", int'(alarm_event), int'(m_evt));
    check("alarm_flag", int'(alarm_flag), int'(m_flag));
    check("alarm_irq", int'(alarm_irq), int'(m_flag && alarm_ie));
    check("rd_data", int'(rd_data), model_read(int'(rd_sel)));
  endtask

  // one clock: predict from applied inputs, advance, compare
  task automatic cycle();
    bit fire;
    bit nflag;
    fire  = sec_tick && model_fire();
    nflag = fire ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    if (wr_en && wr_sel < 6) begin
      m_en[wr_sel]  = wr_data[7];
      m_val[wr_sel] = int'(wr_data) % (1 << width_of(int'(wr_sel)));
    end
    @(posedge clk);
    #1;
    m_evt  = fire;
    m_flag = nflag;
    if (alarm_event) events_seen++;
    compare_all();
    wr_en = 0; sec_tick = 0; flag_clr = 0;
  endtask

  task automatic write_reg(int sel, int data);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 8'(data);
    cycle();
  endtask

  task automatic set_live(int s, int mi, int h, int d, int mo, int w);
    cur_sec = 7'(bcd(s)); cur_min = 7'(bcd(mi)); cur_hour = 6'(bcd(h));
    cur_date = 6'(bcd(d)); cur_month = 5'(bcd(mo)); cur_wday = 3'(w);
  endtask

  task automatic tick();
    sec_tick = 1;
    cycle();
  endtask

  task automatic read_all();
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1;
      check("rd_data", int'(rd_data), model_read(s));
    end
    rd_sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_en[i] = 0; m_val[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    tag = "R1";
    read_all();
    compare_all();

    // R2 write all ones, check padding and enable bit
    tag = "R2";
    for (int s = 0; s < 8; s++) write_reg(s, 8'hFF);
    read_all();
    rd_sel = 3'd2;
    #1 check("hour pad", int'(rd_data), 8'hBF);
    rd_sel = 3'd5;
    #1 check("wday pad", int'(rd_data), 8'h87);
    rd_sel = 3'd7;
    #1 check("unused idx", int'(rd_data), 0);

    // R4 no field enabled: time equals stored values, no event
    tag = "R4";
    write_reg(0, bcd(30)); write_reg(1, bcd(15)); write_reg(2, bcd(8));
    write_reg(3, bcd(21)); write_reg(4, bcd(7));  write_reg(5, 3);
    set_live(30, 15, 8, 21, 7, 3);
    tick(); tick();
    cycle();

    // R3 full match with all six enabled
    tag = "R3";
    write_reg(0, 128 + bcd(30)); write_reg(1, 128 + bcd(15));
    write_reg(2, 128 + bcd(8));  write_reg(3, 128 + bcd(21));
    write_reg(4, 128 + bcd(7));  write_reg(5, 128 + 3);
    read_all();
    tick();
    cycle();
    flag_clr = 1; cycle();
    set_live(31, 15, 8, 21, 7, 3);
    tick();
    set_live(30, 15, 8, 21, 7, 4);
    tick();
    set_live(30, 15, 8, 21, 12, 3);
    tick();

    // R6 match but no tick
    tag = "R6";
    set_live(30, 15, 8, 21, 7, 3);
    repeat (3) cycle();

    // R5 only seconds enabled: once per minute sweep
    tag = "R5";
    for (int i = 1; i < 6; i++) write_reg(i, 0);
    write_reg(0, 128 + bcd(45));
    events_seen = 0;
    for (int mi = 0; mi < 3; mi++) begin
      for (int s = 0; s < 60; s++) begin
        set_live(s, mi, 23, 31, 12, 6);
        tick();
        cycle();
        flag_clr = 1; cycle();
      end
    end
    check("events in 3 minutes", events_seen, 3);

    // R7 sticky flag, clear, and set-over-clear
    tag = "R7";
    set_live(45, 0, 0, 1, 1, 0);
    tick();
    repeat (4) cycle();
    flag_clr = 1; cycle();
    cycle();
    tick();
    flag_clr = 1; sec_tick = 1; cycle();
    cycle();

    // R8 interrupt gating
    tag = "R8";
    alarm_ie = 0;
    #1 check("irq masked", int'(alarm_irq), 0);
    alarm_ie = 1;
    #1 check("irq unmasked", int'(alarm_irq), 1);
    cycle();
    flag_clr = 1; cycle();
    check("irq after clear", int'(alarm_irq), 0);
    alarm_ie = 0;

    // R2 writes to unused indices leave fields untouched
    tag = "R2";
    write_reg(6, 8'h00); write_reg(7, 8'h00);
    read_all();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule